// File: doc/BRIEF.md
# ISA Host Bridge for a Six-DSP Board

This block sits between an ISA-style I/O slave bus and six DSPs. Each DSP exposes an indirect memory-access port, and the six ports share one set of data wires. The board answers to a single window of four word-wide I/O ports. The window's base address is set by a 4-bit jumper value `n`, as `0x360 - 8*n`. Jumper settings therefore step the board downward in 8-byte steps, so boards on the same bus never overlap.

A control register chooses the active DSP. Each host access to the window then becomes a short, fixed strobe sequence on that DSP alone:
- an address latch pulse that loads an internal start address;
- a chip-select frame around a two-cycle write or read strobe, which moves one 16-bit word.

The DSP advances its own internal address after each word, so repeated data-port accesses move a stream of words. A write to the reset port holds the active DSP in reset for a fixed time. All six DSPs are held in reset while the board reset is active and for a short time after it is released.

Host strobes are sampled on the block clock. An access is recognised on the first sampled low level of IOR or IOW. The host keeps a data-port read strobe low for at least eight clocks, and read data is valid from the fifth clock on. All DSP-side control outputs are active high.

Top module: `isa_dsp_bridge`

## Requirements
- R1: A port decodes only when `io_aen` is low, `io_addr[9:3]` equals bits 9:3 of `0x360 - 8*jumper` and `io_addr[0]` is 0. `io_addr[2:1]` then selects the port: 00 data, 01 IDMA address, 10 reset, 11 control.
- R2: A write to the control port stores `io_wdata[2:0]` as the active index and ignores the higher bits. While a decoded read is active, `io_rdata_oe` is high. The control port then reads back `{13'b0, index}`, and the address and reset ports read 0. Outside a decoded read, `io_rdata_oe` is low.
- R3: A write to the address port makes `dsp_alatch[index]` high for exactly one cycle, two rising edges after IOW is first sampled low. During that cycle `dsp_bus_out` equals the written word and `dsp_bus_oe` is high.
- R4: A write to the data port produces a four-cycle `dsp_cs[index]` frame. The frame starts two rising edges after IOW is first sampled low. `dsp_wr[index]` is high in the second and third cycles of the frame only, and the written word is driven on `dsp_bus_out` with `dsp_bus_oe` high.
- R5: A read of the data port produces the same frame with `dsp_rd[index]` in place of `dsp_wr`. `dsp_bus_in` is captured at the last read-strobe edge and is returned on `io_rdata` from the following cycle.
- R6: At most one bit of `dsp_cs`, `dsp_wr`, `dsp_rd` and `dsp_alatch` is high at a time, and only at the stored index. Index values 6 and 7 are still stored, but they produce no strobe and no reset.
- R7: A write to the reset port makes `dsp_reset[index]` high for 16 cycles, from the second rising edge after IOW is first sampled low. The other reset lines are unchanged.
- R8: While `rst_n` is low, all six `dsp_reset` bits are high. After `rst_n` is released they stay high until the 16th rising edge.
- R9: Each falling edge of a host strobe at a decoded address causes one action, however long the strobe is held low. A data or address access that arrives while a strobe sequence is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Board reset, active low, asynchronous assert |
| jumper | input | 4 | Board base selector n |
| io_addr | input | 10 | Host I/O address |
| io_aen | input | 1 | Host DMA-cycle flag; decoding needs it low |
| io_rd_n | input | 1 | Host I/O read strobe, active low |
| io_wr_n | input | 1 | Host I/O write strobe, active low |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Host read data |
| io_rdata_oe | output | 1 | Enable for host read data |
| dsp_bus_out | output | 16 | Shared IDMA data/address to the DSPs |
| dsp_bus_oe | output | 1 | Drive enable for dsp_bus_out |
| dsp_bus_in | input | 16 | Shared IDMA read data from the DSPs |
| dsp_alatch | output | 6 | Per-DSP IDMA address latch strobe |
| dsp_cs | output | 6 | Per-DSP IDMA select |
| dsp_wr | output | 6 | Per-DSP IDMA write strobe |
| dsp_rd | output | 6 | Per-DSP IDMA read strobe |
| dsp_reset | output | 6 | Per-DSP reset |

## Verification
Every result is counted from the rising edge that first samples the host strobe low. The latch pulse, the select frame and the reset pulse all start two edges later. The write and read strobes start three edges later, and captured read data is on the host bus from the fifth. The bench records every DSP-side output at each falling clock edge for 24 cycles after it lowers a strobe. It then compares each recorded cycle against a window it computes from these offsets, so an early, late, stretched or repeated strobe shows up at the exact cycle where it occurs. The base address is swept over all 16 jumper values, and the DSP index over all eight codes.

// File: rtl/isa_dsp_pkg.sv
package isa_dsp_pkg;

  // Port selected by address bits 2:1
  typedef enum logic [1:0] {
    PORT_DATA = 2'b00,
    PORT_ADDR = 2'b01,
    PORT_RST  = 2'b10,
    PORT_CTRL = 2'b11
  } port_e;

  // Strobe sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LATCH,
    SQ_LEAD,
    SQ_STROBE,
    SQ_TRAIL
  } seq_e;

  function automatic port_e port_of(input logic [1:0] a21);
    return port_e'(a21);
  endfunction

endpackage

// File: rtl/isa_port_decode.sv
module isa_port_decode
  import isa_dsp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned JMP_W    = 4,
  parameter logic [ADDR_W-1:0] TOP_BASE = 10'h360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [JMP_W-1:0]  jumper,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_aen,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              hit,
  output port_e             port,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic              rd_act,
  output logic [DATA_W-1:0] wdata_q
);

  localparam int unsigned HI_W = ADDR_W - 3;
  localparam logic [HI_W-1:0] TOP_HI = TOP_BASE[ADDR_W-1:3];

  // Base address bits 9:3: each jumper step moves the board down 8 bytes
  function automatic logic [HI_W-1:0] base_hi(input logic [JMP_W-1:0] n);
    return TOP_HI - HI_W'(n);
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic              aen_q;
  logic              rd_n_q, rd_n_q2;
  logic              wr_n_q, wr_n_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      aen_q   <= 1'b1;
      rd_n_q  <= 1'b1;
      rd_n_q2 <= 1'b1;
      wr_n_q  <= 1'b1;
      wr_n_q2 <= 1'b1;
      wdata_q <= '0;
    end else begin
      addr_q  <= io_addr;
      aen_q   <= io_aen;
      rd_n_q  <= io_rd_n;
      rd_n_q2 <= rd_n_q;
      wr_n_q  <= io_wr_n;
      wr_n_q2 <= wr_n_q;
      wdata_q <= io_wdata;
    end
  end

  assign hit    = !aen_q && !addr_q[0] && (addr_q[ADDR_W-1:3] == base_hi(jumper));
  assign port   = port_of(addr_q[2:1]);
  assign wr_evt = hit && wr_n_q2 && !wr_n_q;
  assign rd_evt = hit && rd_n_q2 && !rd_n_q;
  assign rd_act = hit && !rd_n_q;

endmodule

// File: rtl/idma_sequencer.sv
module idma_sequencer
  import isa_dsp_pkg::*;
#(
  parameter int unsigned NUM        = 6,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_latch,
  input  logic              go_wr,
  input  logic              go_rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [NUM-1:0]    cs,
  output logic [NUM-1:0]    wr,
  output logic [NUM-1:0]    rd,
  output logic [NUM-1:0]    alatch,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              idle
);

  localparam int unsigned CNT_W = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

  seq_e              state;
  logic [IDX_W-1:0]  tgt;
  logic              is_read;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wbuf;
  logic [DATA_W-1:0] rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      tgt     <= '0;
      is_read <= 1'b0;
      cnt     <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (go_latch) begin
            state   <= SQ_LATCH;
            tgt     <= idx;
            wbuf    <= wdata;
            is_read <= 1'b0;
          end else if (go_wr || go_rd) begin
            state   <= SQ_LEAD;
            tgt     <= idx;
            wbuf    <= wdata;
            is_read <= go_rd;
          end
        end
        SQ_LATCH: state <= SQ_IDLE;
        SQ_LEAD: begin
          state <= SQ_STROBE;
          cnt   <= '0;
        end
        SQ_STROBE: begin
          if (cnt == LAST) begin
            state <= SQ_TRAIL;
            if (is_read) rbuf <= bus_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_TRAIL: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  logic in_frame;
  logic in_strobe;
  assign in_frame  = (state == SQ_LEAD) || (state == SQ_STROBE) || (state == SQ_TRAIL);
  assign in_strobe = (state == SQ_STROBE);

  for (genvar i = 0; i < NUM; i++) begin : g_dsp
    logic is_tgt;
    assign is_tgt    = (tgt == IDX_W'(i));
    assign cs[i]     = in_frame && is_tgt;
    assign wr[i]     = in_strobe && !is_read && is_tgt;
    assign rd[i]     = in_strobe && is_read && is_tgt;
    assign alatch[i] = (state == SQ_LATCH) && is_tgt;
  end

  assign bus_out = wbuf;
  assign bus_oe  = (state == SQ_LATCH) || (in_frame && !is_read);
  assign rdata   = rbuf;
  assign idle    = (state == SQ_IDLE);

endmodule

// File: rtl/dsp_reset_gen.sv
module dsp_reset_gen #(
  parameter int unsigned NUM   = 6,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned HOLD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] idx,
  output logic [NUM-1:0]   dsp_rst
);

  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [CW-1:0] left;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          left <= LOAD;
      else if (fire && idx == IDX_W'(i))   left <= LOAD;
      else if (left != '0)                 left <= left - 1'b1;
    end
    assign dsp_rst[i] = (left != '0);
  end

endmodule

// File: rtl/isa_dsp_bridge.sv
module isa_dsp_bridge
  import isa_dsp_pkg::*;
#(
  parameter int unsigned NUM_DSP    = 6,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned JMP_W      = 4,
  parameter logic [ADDR_W-1:0] TOP_BASE = 10'h360,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned RST_HOLD   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [JMP_W-1:0]   jumper,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_aen,
  input  logic               io_rd_n,
  input  logic               io_wr_n,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  output logic               io_rdata_oe,
  output logic [DATA_W-1:0]  dsp_bus_out,
  output logic               dsp_bus_oe,
  input  logic [DATA_W-1:0]  dsp_bus_in,
  output logic [NUM_DSP-1:0] dsp_alatch,
  output logic [NUM_DSP-1:0] dsp_cs,
  output logic [NUM_DSP-1:0] dsp_wr,
  output logic [NUM_DSP-1:0] dsp_rd,
  output logic [NUM_DSP-1:0] dsp_reset
);

  localparam int unsigned IDX_W = $clog2(NUM_DSP);

  // Decoder outputs
  logic              hit;
  port_e             port;
  logic              wr_evt, rd_evt, rd_act;
  logic [DATA_W-1:0] wdata_q;

  isa_port_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .JMP_W(JMP_W), .TOP_BASE(TOP_BASE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .jumper(jumper), .io_addr(io_addr),
    .io_aen(io_aen), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wdata(io_wdata),
    .hit(hit), .port(port), .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_act(rd_act),
    .wdata_q(wdata_q)
  );

  // Named per-port events, before the index check
  logic ev_ctrl_wr, ev_addr_wr_raw, ev_data_wr_raw, ev_data_rd_raw, ev_rst_wr_raw;
  assign ev_ctrl_wr     = wr_evt && (port == PORT_CTRL);
  assign ev_addr_wr_raw = wr_evt && (port == PORT_ADDR);
  assign ev_data_wr_raw = wr_evt && (port == PORT_DATA);
  assign ev_data_rd_raw = rd_evt && (port == PORT_DATA);
  assign ev_rst_wr_raw  = wr_evt && (port == PORT_RST);

  // Active DSP index register
  logic [IDX_W-1:0] sel_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_idx <= '0;
    else if (ev_ctrl_wr) sel_idx <= wdata_q[IDX_W-1:0];
  end

  logic sel_ok;
  assign sel_ok = (sel_idx < IDX_W'(NUM_DSP));

  logic [NUM_DSP-1:0] sel_mask;
  for (genvar i = 0; i < NUM_DSP; i++) begin : g_mask
    assign sel_mask[i] = (sel_idx == IDX_W'(i));
  end

  logic seq_idle;
  logic [DATA_W-1:0] seq_rdata;

  idma_sequencer #(
    .NUM(NUM_DSP), .IDX_W(IDX_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_latch(ev_addr_wr_raw && sel_ok),
    .go_wr(ev_data_wr_raw && sel_ok),
    .go_rd(ev_data_rd_raw && sel_ok),
    .idx(sel_idx), .wdata(wdata_q), .bus_in(dsp_bus_in),
    .cs(dsp_cs), .wr(dsp_wr), .rd(dsp_rd), .alatch(dsp_alatch),
    .bus_out(dsp_bus_out), .bus_oe(dsp_bus_oe), .rdata(seq_rdata), .idle(seq_idle)
  );

  dsp_reset_gen #(
    .NUM(NUM_DSP), .IDX_W(IDX_W), .HOLD(RST_HOLD)
  ) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(ev_rst_wr_raw && sel_ok), .idx(sel_idx),
    .dsp_rst(dsp_reset)
  );

  // Host read mux
  always_comb begin
    io_rdata = '0;
    if (rd_act) begin
      unique case (port)
        PORT_DATA: io_rdata = seq_rdata;
        PORT_CTRL: io_rdata = DATA_W'(sel_idx);
        default:   io_rdata = '0;
      endcase
    end
  end
  assign io_rdata_oe = rd_act;

endmodule

// File: rtl/isa_dsp_bridge_chk.sv
module isa_dsp_bridge_chk #(
  parameter int unsigned NUM   = 6,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM-1:0]   dsp_cs,
  input logic [NUM-1:0]   dsp_wr,
  input logic [NUM-1:0]   dsp_rd,
  input logic [NUM-1:0]   dsp_alatch,
  input logic [NUM-1:0]   dsp_reset,
  input logic             dsp_bus_oe,
  input logic [IDX_W-1:0] sel_idx,
  input logic [NUM-1:0]   sel_mask,
  input logic             ev_data_wr_raw,
  input logic             ev_rst_wr_raw,
  input logic             seq_idle
);

  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dsp_cs) && $onehot0(dsp_alatch));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((dsp_wr | dsp_rd) & ~dsp_cs) == '0);

  p_cs_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dsp_wr) |-> $past(|dsp_cs));

  p_cs_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|dsp_wr) |-> (|dsp_cs));

  p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dsp_wr) |=> (|dsp_wr));

  p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dsp_rd) |=> (|dsp_rd));

  p_latch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dsp_alatch) |-> dsp_bus_oe ##1 !(|dsp_alatch));

  p_bad_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_wr_raw && seq_idle && sel_idx >= IDX_W'(NUM)) |=> (dsp_cs == '0));

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst_wr_raw |=> ((dsp_reset & $past(sel_mask)) == $past(sel_mask)));

  p_por_hold_r8: assert property (@(posedge clk)
    !rst_n |=> (&dsp_reset));

endmodule

bind isa_dsp_bridge isa_dsp_bridge_chk #(.NUM(NUM_DSP), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsp_cs(dsp_cs), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
  .dsp_alatch(dsp_alatch), .dsp_reset(dsp_reset), .dsp_bus_oe(dsp_bus_oe),
  .sel_idx(sel_idx), .sel_mask(sel_mask), .ev_data_wr_raw(ev_data_wr_raw),
  .ev_rst_wr_raw(ev_rst_wr_raw), .seq_idle(seq_idle)
);

// File: tb/isa_dsp_bridge_bench.sv
module isa_dsp_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  jumper = 4'd0;
  logic [9:0]  io_addr = '0;
  logic        io_aen = 1'b1;
  logic        io_rd_n = 1'b1;
  logic        io_wr_n = 1'b1;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_rdata_oe;
  logic [15:0] dsp_bus_out;
  logic        dsp_bus_oe;
  logic [15:0] dsp_bus_in = '0;
  logic [5:0]  dsp_alatch, dsp_cs, dsp_wr, dsp_rd, dsp_reset;

  always #2 clk = ~clk;

  isa_dsp_bridge u_isa_dsp_bridge (
    .clk(clk), .rst_n(rst_n), .jumper(jumper), .io_addr(io_addr), .io_aen(io_aen),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .dsp_bus_out(dsp_bus_out), .dsp_bus_oe(dsp_bus_oe),
    .dsp_bus_in(dsp_bus_in), .dsp_alatch(dsp_alatch), .dsp_cs(dsp_cs),
    .dsp_wr(dsp_wr), .dsp_rd(dsp_rd), .dsp_reset(dsp_reset)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Per-cycle record after a strobe, index k = falling edges after the strobe
  logic [5:0]  cs_l [0:24];
  logic [5:0]  wr_l [0:24];
  logic [5:0]  rd_l [0:24];
  logic [5:0]  al_l [0:24];
  logic [5:0]  rs_l [0:24];
  logic [15:0] bo_l [0:24];
  logic        oe_l [0:24];
  logic [15:0] rd_val;
  logic        rd_oe;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] base_of(input int n);
    return 10'(32'h360 - 8 * n);
  endfunction

  function automatic logic [5:0] mask_of(input int idx);
    return (idx < 6) ? 6'(1 << idx) : 6'b0;
  endfunction

  // Lower a strobe for 8 cycles, record 24 cycles
  task automatic access(input bit is_rd, input logic [9:0] a, input logic [15:0] d,
                        input bit aen_v);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_aen = aen_v;
    if (is_rd) io_rd_n = 1'b0; else io_wr_n = 1'b0;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      cs_l[k] = dsp_cs; wr_l[k] = dsp_wr; rd_l[k] = dsp_rd; al_l[k] = dsp_alatch;
      rs_l[k] = dsp_reset; bo_l[k] = dsp_bus_out; oe_l[k] = dsp_bus_oe;
      if (k == 8) begin
        rd_val = io_rdata; rd_oe = io_rdata_oe;
        io_rd_n = 1'b1; io_wr_n = 1'b1; io_aen = 1'b1;
      end
    end
  endtask

  // Expected frame windows
  function automatic bit in_cs(input int k);
    return (k >= 2) && (k <= 5);
  endfunction
  function automatic bit in_strobe(input int k);
    return (k >= 3) && (k <= 4);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] b;
    // R8: power-on hold
    repeat (3) @(negedge clk);
    chk("R8", "resets during rst_n", 32'(dsp_reset), 32'h3F);
    chk("R2", "rdata_oe in reset", 32'(io_rdata_oe), 32'h0);
    chk("R6", "cs in reset", 32'(dsp_cs), 32'h0);
    rst_n = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 1 || k == 15) chk("R8", "resets held after release", 32'(dsp_reset), 32'h3F);
      if (k == 16) chk("R8", "resets released at 16th edge", 32'(dsp_reset), 32'h0);
    end

    // R1/R2: sweep all jumper settings
    for (int n = 0; n < 16; n++) begin
      int idx;
      idx = n % 6;
      jumper = 4'(n);
      b = base_of(n);
      access(0, b + 10'd6, 16'hFFF8 | 16'(idx), 0);
      access(1, b + 10'd6, 16'h0, 0);
      chk("R1", "control read oe", 32'(rd_oe), 32'h1);
      chk("R2", "control readback", 32'(rd_val), 32'(idx));
      access(0, b + 10'd14, 16'(5 - idx), 0);
      access(0, b - 10'd2, 16'(5 - idx), 0);
      access(0, b + 10'd6, 16'(5 - idx), 1);
      access(1, b + 10'd6, 16'h0, 0);
      chk("R1", "misses and AEN leave control", 32'(rd_val), 32'(idx));
      access(1, b + 10'd7, 16'h0, 0);
      chk("R1", "odd address no decode", 32'(rd_oe), 32'h0);
      access(1, b + 10'd14, 16'h0, 0);
      chk("R1", "next window no decode", 32'(rd_oe), 32'h0);
      access(1, b + 10'd2, 16'h0, 0);
      chk("R2", "address port reads zero", {15'h0, rd_oe, rd_val}, 32'h1_0000);
    end

    // Per-DSP strobes with jumper 3
    jumper = 4'd3;
    b = base_of(3);
    for (int idx = 0; idx < 8; idx++) begin
      logic [5:0] m;
      int pulses;
      m = mask_of(idx);
      access(0, b + 10'd6, 16'(idx), 0);

      access(0, b + 10'd2, 16'h4000 + 16'(idx), 0);
      for (int k = 1; k <= 8; k++)
        chk("R3", $sformatf("alatch dsp%0d k%0d", idx, k), 32'(al_l[k]),
            32'((k == 2) ? m : 6'b0));
      if (idx < 6) begin
        chk("R3", "latch bus word", 32'(bo_l[2]), 32'h4000 + idx);
        chk("R3", "latch bus oe", 32'(oe_l[2]), 32'h1);
      end

      access(0, b + 10'd0, 16'h1230 + 16'(idx), 0);
      pulses = 0;
      for (int k = 1; k <= 24; k++) begin
        chk("R4", $sformatf("cs wr dsp%0d k%0d", idx, k), {18'h0, cs_l[k], wr_l[k], rd_l[k]},
            {18'h0, (in_cs(k) ? m : 6'b0), (in_strobe(k) ? m : 6'b0), 6'b0});
        if (k > 1 && wr_l[k] != 0 && wr_l[k-1] == 0) pulses++;
      end
      chk("R9", "one write pulse per strobe", 32'(pulses), 32'((idx < 6) ? 1 : 0));
      if (idx < 6) begin
        chk("R4", "write bus word", 32'(bo_l[3]), 32'h1230 + idx);
        chk("R4", "write bus oe", 32'(oe_l[4]), 32'h1);
      end

      dsp_bus_in = 16'hB000 | 16'(idx << 4) | 16'h5;
      access(1, b + 10'd0, 16'h0, 0);
      for (int k = 1; k <= 8; k++)
        chk("R5", $sformatf("cs rd dsp%0d k%0d", idx, k), {18'h0, cs_l[k], wr_l[k], rd_l[k]},
            {18'h0, (in_cs(k) ? m : 6'b0), 6'b0, (in_strobe(k) ? m : 6'b0)});
      if (idx < 6) chk("R5", "read data", 32'(rd_val), 32'(dsp_bus_in));

      access(0, b + 10'd4, 16'h0, 0);
      for (int k = 1; k <= 24; k++)
        chk("R7", $sformatf("reset dsp%0d k%0d", idx, k), 32'(rs_l[k]),
            32'(((k >= 2) && (k <= 17)) ? m : 6'b0));
      access(1, b + 10'd4, 16'h0, 0);
      chk("R2", "reset port reads zero", 32'(rd_val), 32'h0);
      access(1, b + 10'd6, 16'h0, 0);
      chk("R6", "stored index incl. invalid", 32'(rd_val), 32'(idx));
    end

    // R9: back-to-back data writes each make one frame
    access(0, b + 10'd6, 16'd2, 0);
    for (int rep = 0; rep < 2; rep++) begin
      access(0, b, 16'hC0DE + 16'(rep), 0);
      chk("R9", "repeat write frame", 32'(wr_l[3]), 32'h4);
      chk("R9", "repeat write word", 32'(bo_l[3]), 32'hC0DE + rep);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule